// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is a lane-parallel scratchpad memory. One request group carries up to `LANES` lane accesses. Each lane has an active flag, a write flag, a word address and a write word. The storage is split into `BANKS` independent single-port banks. A word address selects its bank from its low bits and its row from the remaining bits, so consecutive words fall into consecutive banks. Each bank can serve one word per clock.

A group is taken in with a valid/ready handshake and is then worked off over one or more serve cycles. In every serve cycle, each bank takes its lowest-numbered lane that is still waiting. In the same cycle it also serves every other waiting lane that names the same word in the same direction. Lanes that hit different words of one bank are therefore spread over extra cycles. A single word read by every lane is broadcast in one cycle.

When the last access has finished, the block pulses a done flag. At the same time it presents the read word for every lane and the number of serve cycles the group took. That number is the conflict degree: the largest count of distinct accesses aimed at any one bank.

Top module: `spm_banked`

## Requirements
- R1: Word address `a` lives in bank `a mod BANKS` at row `a / BANKS`. Every word written can be read back at its own address without aliasing any other address.
- R2: A group whose active lanes all target different banks finishes with `rsp_degree` equal to 1. `rsp_done` is high in the second cycle after the accepting clock edge.
- R3: `rsp_degree` equals the largest number of distinct (word, direction) accesses aimed at any single bank. `rsp_done` follows the accepting edge by `max(degree,1)+1` cycles.
- R4: With `BANKS` = 16 and lane `i` addressing `i*s`, an odd stride `s` gives degree 1, `s` = 2 gives degree 2 and `s` = 8 gives degree 8.
- R5: When every active lane reads one and the same word, the group completes in one serve cycle and all lanes return that word.
- R6: Within a bank, waiting lanes are served lowest lane index first. Lanes reading the same word as the lane being served are served in the same cycle. A read in a higher lane therefore sees a write made to the same word by a lower lane of the same group.
- R7: When several lanes of a group write the same word, the data of the highest-numbered of those lanes remains stored.
- R8: `req_ready` is high only while no group is in progress. It drops in the cycle after a group is accepted. A `req_valid` presented while `req_ready` is low is ignored and changes no stored word.
- R9: `rsp_done` is a single-cycle pulse. `rsp_degree` changes only in a cycle where `rsp_done` is high, and holds until the next group completes.
- R10: Inactive lanes perform no access and return zero on `rsp_rdata`. Write lanes also return zero. A group with no active lane completes with degree 0, two cycles after acceptance.
- R11: After reset, `req_ready` is 1, `rsp_done` is 0 and `rsp_degree` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | Block is idle and takes a group |
| lane_act | input | LANES | Per-lane active flag |
| lane_wr | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | LANES*AW | Per-lane word address, lane 0 in the low bits |
| lane_wdata | input | LANES*DW | Per-lane write word, lane 0 in the low bits |
| rsp_done | output | 1 | One-cycle pulse when the group has finished |
| rsp_rdata | output | LANES*DW | Per-lane read word, valid while `rsp_done` is high and held after |
| rsp_degree | output | CW | Serve cycles taken by the last finished group |

## Verification
The bench builds the block with 16 lanes, 16 banks and only 16 rows per bank. This brings the whole 256-word space within reach: every word can be filled and read back, and the full stride sweep from 1 to 16 stays inside the address space, including the worst case of all lanes in one bank. Small hand-built groups cover merging, lowest-lane ordering, write collisions, blocked handshakes and the empty group. Expected degrees and read words come from a per-bank distinct-access count and a shadow memory kept in the bench.

// File: rtl/spm_pkg.sv
package spm_pkg;

   typedef enum logic [1:0] {
      SP_IDLE  = 2'd0,
      SP_SERVE = 2'd1,
      SP_DRAIN = 2'd2
   } spm_phase_e;

endpackage

// File: rtl/spm_bank.sv
module spm_bank #(
   parameter int DW   = 32,
   parameter int ROWS = 256,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          en,
   input  logic          wr,
   input  logic [RW-1:0] row,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] rd
);

   logic [DW-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (wr) begin
            cells[row] <= wd;
         end else begin
            rd <= cells[row];
         end
      end
   end

endmodule

// File: rtl/spm_arbiter.sv
module spm_arbiter #(
   parameter int LANES = 16,
   parameter int BANKS = 16,
   parameter int ROWS  = 256,
   parameter int DW    = 32,
   localparam int BW   = $clog2(BANKS),
   localparam int RW   = $clog2(ROWS),
   localparam int AW   = BW + RW,
   localparam int LIW  = $clog2(LANES)
) (
   input  logic [LANES-1:0]         pend,
   input  logic [LANES-1:0]         wr_q,
   input  logic [LANES-1:0][AW-1:0] addr_q,
   input  logic [LANES-1:0][DW-1:0] wd_q,
   output logic [LANES-1:0]         served,
   output logic [BANKS-1:0]         bk_en,
   output logic [BANKS-1:0]         bk_wr,
   output logic [BANKS-1:0][RW-1:0] bk_row,
   output logic [BANKS-1:0][DW-1:0] bk_wd
);

   logic [BANKS-1:0][LIW-1:0] lead_idx;
   logic [BANKS-1:0]          lead_ok;

   // pick the lowest waiting lane of every bank
   always_comb begin
      for (int b = 0; b < BANKS; b++) begin
         lead_ok[b]  = 1'b0;
         lead_idx[b] = '0;
         for (int l = LANES - 1; l >= 0; l--) begin
            if (pend[l] && (addr_q[l][BW-1:0] == BW'(b))) begin
               lead_ok[b]  = 1'b1;
               lead_idx[b] = LIW'(l);
            end
         end
      end
   end

   // a lane rides along when it matches its bank leader in word and direction
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         served[l] = pend[l] && lead_ok[addr_q[l][BW-1:0]]
                  && (addr_q[lead_idx[addr_q[l][BW-1:0]]] == addr_q[l])
                  && (wr_q[lead_idx[addr_q[l][BW-1:0]]] == wr_q[l]);
      end
   end

   // bank port drive; ascending scan leaves the highest writer's word
   always_comb begin
      for (int b = 0; b < BANKS; b++) begin
         bk_en[b]  = lead_ok[b];
         bk_wr[b]  = wr_q[lead_idx[b]];
         bk_row[b] = addr_q[lead_idx[b]][AW-1:BW];
         bk_wd[b]  = '0;
         for (int l = 0; l < LANES; l++) begin
            if (served[l] && wr_q[l] && (addr_q[l][BW-1:0] == BW'(b))) begin
               bk_wd[b] = wd_q[l];
            end
         end
      end
   end

   // R6
   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         if (served[l]) begin
            row_match_chk: assert (bk_en[addr_q[l][BW-1:0]]
                                   && (bk_row[addr_q[l][BW-1:0]] == addr_q[l][AW-1:BW])
                                   && (bk_wr[addr_q[l][BW-1:0]] == wr_q[l]))
               else $error("served lane does not match its bank port");
         end
      end
   end

endmodule

// File: rtl/spm_collect.sv
module spm_collect #(
   parameter int LANES = 16,
   parameter int BANKS = 16,
   parameter int DW    = 32,
   localparam int BW   = $clog2(BANKS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic [LANES-1:0]          cap,
   input  logic [LANES-1:0]          wr_q,
   input  logic [LANES-1:0][BW-1:0]  bsel,
   input  logic [BANKS-1:0][DW-1:0]  bk_rd,
   output logic [LANES-1:0][DW-1:0]  res
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res[l] <= '0;
         end else if (clear) begin
            res[l] <= '0;
         end else if (cap[l] && !wr_q[l]) begin
            res[l] <= bk_rd[bsel[l]];
         end
      end
   end

endmodule

// File: rtl/spm_banked.sv
module spm_banked #(
   parameter int LANES = 16,
   parameter int BANKS = 16,
   parameter int ROWS  = 256,
   parameter int DW    = 32,
   localparam int BW   = $clog2(BANKS),
   localparam int RW   = $clog2(ROWS),
   localparam int AW   = BW + RW,
   localparam int CW   = $clog2(LANES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [LANES-1:0]    lane_act,
   input  logic [LANES-1:0]    lane_wr,
   input  logic [LANES*AW-1:0] lane_addr,
   input  logic [LANES*DW-1:0] lane_wdata,
   output logic                rsp_done,
   output logic [LANES*DW-1:0] rsp_rdata,
   output logic [CW-1:0]       rsp_degree
);

   import spm_pkg::*;

   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two of at least 2");
   end
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_bad_rows
      $error("ROWS must be a power of two of at least 2");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end

   spm_phase_e                phase;
   logic [LANES-1:0]          pend;
   logic [LANES-1:0]          wr_q;
   logic [LANES-1:0][AW-1:0]  addr_q;
   logic [LANES-1:0][DW-1:0]  wd_q;
   logic [LANES-1:0]          served;
   logic [LANES-1:0]          served_q;
   logic [LANES-1:0]          pend_left;
   logic [CW-1:0]             cnt;
   logic                      accept;

   logic [BANKS-1:0]          bk_en;
   logic [BANKS-1:0]          bk_wr;
   logic [BANKS-1:0][RW-1:0]  bk_row;
   logic [BANKS-1:0][DW-1:0]  bk_wd;
   logic [BANKS-1:0][DW-1:0]  bk_rd;
   logic [LANES-1:0][BW-1:0]  bsel;
   logic [LANES-1:0][DW-1:0]  res;

   assign req_ready = (phase == SP_IDLE);
   assign accept    = req_valid && req_ready;
   assign pend_left = pend & ~served;
   assign rsp_rdata = res;

   for (genvar l = 0; l < LANES; l++) begin : g_bsel
      assign bsel[l] = addr_q[l][BW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= SP_IDLE;
         pend       <= '0;
         wr_q       <= '0;
         addr_q     <= '0;
         wd_q       <= '0;
         served_q   <= '0;
         cnt        <= '0;
         rsp_degree <= '0;
         rsp_done   <= 1'b0;
      end else begin
         rsp_done <= 1'b0;
         served_q <= '0;
         unique case (phase)
            SP_IDLE: begin
               if (accept) begin
                  pend   <= lane_act;
                  wr_q   <= lane_wr;
                  addr_q <= lane_addr;
                  wd_q   <= lane_wdata;
                  cnt    <= '0;
                  phase  <= SP_SERVE;
               end
            end
            SP_SERVE: begin
               pend     <= pend_left;
               served_q <= served;
               if (served != '0) begin
                  cnt <= cnt + 1'b1;
               end
               if (pend_left == '0) begin
                  phase <= SP_DRAIN;
               end
            end
            SP_DRAIN: begin
               rsp_done   <= 1'b1;
               rsp_degree <= cnt;
               phase      <= SP_IDLE;
            end
            default: phase <= SP_IDLE;
         endcase
      end
   end

   spm_arbiter #(
      .LANES (LANES),
      .BANKS (BANKS),
      .ROWS  (ROWS),
      .DW    (DW)
   ) arb_i (
      .pend   (pend),
      .wr_q   (wr_q),
      .addr_q (addr_q),
      .wd_q   (wd_q),
      .served (served),
      .bk_en  (bk_en),
      .bk_wr  (bk_wr),
      .bk_row (bk_row),
      .bk_wd  (bk_wd)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      spm_bank #(
         .DW   (DW),
         .ROWS (ROWS)
      ) bank_i (
         .clk (clk),
         .en  (bk_en[b] && (phase == SP_SERVE)),
         .wr  (bk_wr[b]),
         .row (bk_row[b]),
         .wd  (bk_wd[b]),
         .rd  (bk_rd[b])
      );
   end

   spm_collect #(
      .LANES (LANES),
      .BANKS (BANKS),
      .DW    (DW)
   ) col_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .cap   (served_q),
      .wr_q  (wr_q),
      .bsel  (bsel),
      .bk_rd (bk_rd),
      .res   (res)
   );

   // R8
   accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R9
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R9
   degree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_degree) |-> rsp_done);

   // R3
   pend_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == SP_SERVE && pend != '0) |=> ($countones(pend) < $past($countones(pend))));

   // R3
   degree_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_degree <= CW'(LANES)));

endmodule

// File: tb/spm_banked_tb_top.sv
`timescale 1ns/1ps
module spm_banked_tb_top;

   localparam int LANES = 16;
   localparam int BANKS = 16;
   localparam int ROWS  = 16;
   localparam int DW    = 32;
   localparam int AW    = 8;
   localparam int CW    = 5;
   localparam int WORDS = BANKS * ROWS;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [LANES-1:0]    lane_act = '0;
   logic [LANES-1:0]    lane_wr = '0;
   logic [LANES*AW-1:0] lane_addr = '0;
   logic [LANES*DW-1:0] lane_wdata = '0;
   logic                rsp_done;
   logic [LANES*DW-1:0] rsp_rdata;
   logic [CW-1:0]       rsp_degree;

   always #4 clk = ~clk;

   spm_banked #(
      .LANES (LANES),
      .BANKS (BANKS),
      .ROWS  (ROWS),
      .DW    (DW)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .lane_act   (lane_act),
      .lane_wr    (lane_wr),
      .lane_addr  (lane_addr),
      .lane_wdata (lane_wdata),
      .rsp_done   (rsp_done),
      .rsp_rdata  (rsp_rdata),
      .rsp_degree (rsp_degree)
   );

   int n_chk = 0;
   int n_fail = 0;
   int wd_cnt = 0;
   bit ended = 0;

   logic [31:0] mdl [WORDS];
   bit          g_act [LANES];
   bit          g_wr  [LANES];
   int          g_addr [LANES];
   logic [31:0] g_wd  [LANES];

   function automatic logic [31:0] fill_val(int a);
      return 32'h5A00_0000 + 32'(a) * 32'd977;
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      wd_cnt++;
      if (wd_cnt > 150000 && !ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", wd_cnt, 150000);
         finish_run();
      end
   end

   task automatic clear_group();
      for (int l = 0; l < LANES; l++) begin
         g_act[l] = 0; g_wr[l] = 0; g_addr[l] = 0; g_wd[l] = '0;
      end
   endtask

   function automatic int exp_degree();
      int worst = 0;
      for (int b = 0; b < BANKS; b++) begin
         int n = 0;
         for (int l = 0; l < LANES; l++) begin
            if (g_act[l] && (g_addr[l] % BANKS) == b) begin
               bit seen = 0;
               for (int k = 0; k < l; k++) begin
                  if (g_act[k] && g_addr[k] == g_addr[l] && g_wr[k] == g_wr[l]) seen = 1;
               end
               if (!seen) n++;
            end
         end
         if (n > worst) worst = n;
      end
      return worst;
   endfunction

   task automatic drive_group();
      for (int l = 0; l < LANES; l++) begin
         lane_act[l]             = g_act[l];
         lane_wr[l]              = g_wr[l];
         lane_addr[l*AW +: AW]   = AW'(g_addr[l]);
         lane_wdata[l*DW +: DW]  = g_wd[l];
      end
   endtask

   task automatic run_group(string tag);
      logic [31:0] er [LANES];
      int          deg_e;
      int          cyc;
      int          lead;
      deg_e = exp_degree();
      for (int l = 0; l < LANES; l++) begin
         er[l] = '0;
         if (g_act[l]) begin
            lead = l;
            for (int k = l - 1; k >= 0; k--) begin
               if (g_act[k] && g_addr[k] == g_addr[l] && g_wr[k] == g_wr[l]) lead = k;
            end
            if (lead == l) begin
               if (g_wr[l]) begin
                  for (int k = 0; k < LANES; k++) begin
                     if (g_act[k] && g_wr[k] && g_addr[k] == g_addr[l]) mdl[g_addr[l]] = g_wd[k];
                  end
               end else begin
                  er[l] = mdl[g_addr[l]];
               end
            end else if (!g_wr[l]) begin
               er[l] = er[lead];
            end
         end
      end
      @(negedge clk);
      check(req_ready == 1'b1, {tag, " R8 ready before issue"}, 32'(req_ready), 1);
      drive_group();
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      while (!rsp_done && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      check(32'(rsp_degree) == 32'(deg_e), {tag, " degree"}, 32'(rsp_degree), 32'(deg_e));
      check(cyc == ((deg_e < 1 ? 1 : deg_e) + 1), {tag, " R3 latency"}, 32'(cyc),
            32'((deg_e < 1 ? 1 : deg_e) + 1));
      for (int l = 0; l < LANES; l++) begin
         check(rsp_rdata[l*DW +: DW] == er[l], {tag, " read word"}, rsp_rdata[l*DW +: DW], er[l]);
      end
   endtask

   initial begin
      for (int a = 0; a < WORDS; a++) mdl[a] = '0;
      clear_group();
      repeat (3) @(negedge clk);
      // R11 reset state
      check(req_ready == 1'b1, "R11 ready", 32'(req_ready), 1);
      check(rsp_done == 1'b0, "R11 done", 32'(rsp_done), 0);
      check(rsp_degree == '0, "R11 degree", 32'(rsp_degree), 0);
      rst_n = 1'b1;

      // R1 R2 fill every word, one row per group, write lanes return zero (R10)
      for (int g = 0; g < ROWS; g++) begin
         for (int l = 0; l < LANES; l++) begin
            g_act[l] = 1; g_wr[l] = 1; g_addr[l] = g * BANKS + l; g_wd[l] = fill_val(g * BANKS + l);
         end
         run_group("R2 R10 fill");
      end
      // R1 read back, lanes reversed over banks
      for (int g = 0; g < ROWS; g++) begin
         for (int l = 0; l < LANES; l++) begin
            g_act[l] = 1; g_wr[l] = 0; g_addr[l] = g * BANKS + (LANES - 1 - l); g_wd[l] = '0;
         end
         run_group("R1 readback");
      end

      // R3 R4 stride sweep
      for (int s = 1; s <= 16; s++) begin
         for (int b = 0; b < 3; b++) begin
            for (int l = 0; l < LANES; l++) begin
               g_act[l] = 1; g_wr[l] = 0; g_addr[l] = (b + s * l) % WORDS; g_wd[l] = '0;
            end
            if (s % 2 == 1)
               check(exp_degree() == 1, "R4 odd stride model", 32'(exp_degree()), 1);
            if (s == 2)
               check(exp_degree() == 2, "R4 stride2 model", 32'(exp_degree()), 2);
            if (s == 8)
               check(exp_degree() == 8, "R4 stride8 model", 32'(exp_degree()), 8);
            run_group((s % 2 == 1 || s == 2 || s == 8) ? "R4 stride" : "R3 stride");
         end
      end

      // R5 broadcast
      clear_group();
      for (int l = 0; l < LANES; l++) begin g_act[l] = 1; g_addr[l] = 37; end
      run_group("R5 broadcast");

      // R6 merge of same-word reads, two words in bank 5, R10 idle lanes
      clear_group();
      g_act[0] = 1; g_addr[0] = 5;
      g_act[2] = 1; g_addr[2] = 5;
      g_act[4] = 1; g_addr[4] = 5;
      g_act[1] = 1; g_addr[1] = 21;
      g_act[3] = 1; g_addr[3] = 21;
      run_group("R6 R10 merge");

      // R6 lowest lane first: write by lane 0 seen by read of lane 1
      clear_group();
      g_act[0] = 1; g_wr[0] = 1; g_addr[0] = 9; g_wd[0] = 32'hCAFE_0009;
      g_act[1] = 1; g_addr[1] = 9;
      run_group("R6 order");
      check(mdl[9] == 32'hCAFE_0009, "R6 model", mdl[9], 32'hCAFE_0009);

      // R7 write collisions
      clear_group();
      for (int l = 0; l < LANES; l++) begin
         g_act[l] = 1; g_wr[l] = 1; g_addr[l] = 50; g_wd[l] = 32'hB000_0000 + 32'(l);
      end
      run_group("R7 all write");
      clear_group();
      g_act[3] = 1; g_wr[3] = 1; g_addr[3] = 60; g_wd[3] = 32'h0000_0A03;
      g_act[7] = 1; g_wr[7] = 1; g_addr[7] = 60; g_wd[7] = 32'h0000_0A07;
      g_act[5] = 1; g_wr[5] = 1; g_addr[5] = 76; g_wd[5] = 32'h0000_0A05;
      run_group("R7 mixed write");
      clear_group();
      g_act[0] = 1; g_addr[0] = 50;
      g_act[1] = 1; g_addr[1] = 60;
      g_act[2] = 1; g_addr[2] = 76;
      run_group("R7 readback");
      check(mdl[50] == 32'hB000_000F && mdl[60] == 32'h0000_0A07, "R7 model", mdl[60], 32'h0000_0A07);

      // R10 empty group
      clear_group();
      run_group("R10 empty");

      // R8 R9 blocked request while busy
      clear_group();
      for (int l = 0; l < LANES; l++) begin g_act[l] = 1; g_addr[l] = 16 * l; end
      @(negedge clk);
      drive_group();
      req_valid = 1'b1;
      @(negedge clk);
      clear_group();
      for (int l = 0; l < LANES; l++) begin
         g_act[l] = 1; g_wr[l] = 1; g_addr[l] = 3; g_wd[l] = 32'hDEAD_0000;
      end
      drive_group();
      for (int i = 0; i < 5; i++) begin
         check(req_ready == 1'b0, "R8 busy ready", 32'(req_ready), 0);
         check(rsp_done == 1'b0 && rsp_degree == CW'(0), "R9 degree held", 32'(rsp_degree), 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      for (int i = 0; i < 40 && !rsp_done; i++) @(negedge clk);
      check(rsp_degree == CW'(16), "R3 one bank degree", 32'(rsp_degree), 16);
      check(req_ready == 1'b1, "R8 ready with done", 32'(req_ready), 1);
      @(negedge clk);
      check(rsp_done == 1'b0, "R9 pulse width", 32'(rsp_done), 0);
      check(rsp_degree == CW'(16), "R9 degree kept", 32'(rsp_degree), 16);
      clear_group();
      g_act[0] = 1; g_addr[0] = 3;
      run_group("R8 ignored write");
      check(mdl[3] == fill_val(3), "R8 model", mdl[3], fill_val(3));

      finish_run();
   end

endmodule